// File: doc/BRIEF.md
# Graphics DRAM Command Decoder and Bank Tracker

This block sits on the memory side of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the command strobes (clock enable, chip select, row strobe, column strobe, write enable and the special-function strobe), the bank select and the auto-precharge address bit. It resolves them into exactly one command and presents that command as a one-hot vector, one cycle after the sampling edge.

It also tracks whether each bank holds an open row. Every command is checked for legality against that state. An illegal command is still reported as decoded, but it raises a flag for that one cycle and leaves the bank state untouched. The special-function strobe turns the ordinary command set into its graphics variants:

- a mode load becomes a special mode load;
- an activate becomes an activate with per-bit write masking;
- a write becomes a block write.

The auto-precharge bit has two uses. It selects single-bank or all-bank precharge, and it attaches auto-precharge to column accesses.

Top module: `sgram_cmd_decode`

## Requirements
- R1: `cmd_oh` is one-hot with bit indices 0 deselect, 1 NOP, 2 mode load, 3 special mode load, 4 activate, 5 activate with write mask, 6 read, 7 write, 8 block write, 9 burst stop, 10 single-bank precharge, 11 all-bank precharge, 12 auto refresh, 13 self-refresh entry. A synchronous reset (`rst_n` low) gives NOP, both banks idle, and `cmd_bank`, `cmd_ap` and `cmd_illegal` all 0.
- R2: With `cs_n` high the command is deselect, `cmd_illegal` is 0 and bank state does not change.
- R3: If `cke` was low at the previous edge, the command is deselect whatever the other strobes are, and bank state does not change.
- R4: With `cs_n` low, `ras_n`/`cas_n`/`we_n` = 0/0/0 decodes as mode load when `dsf`=0 and special mode load when `dsf`=1. 0/1/1 decodes as activate (`dsf`=0) or activate with write mask (`dsf`=1). 1/0/0 decodes as write (`dsf`=0) or block write (`dsf`=1).
- R5: With `cs_n` low, 1/1/1 is NOP, 1/0/1 is read and 1/1/0 is burst stop, independent of `dsf`.
- R6: A legal activate of either kind sets `bank_open[ba]`. Bank 0 is selected by `ba`=0 and bank 1 by `ba`=1.
- R7: 0/1/0 with `a8`=0 is a single-bank precharge that closes only bank `ba`. With `a8`=1 it is an all-bank precharge that closes both banks and reports `cmd_bank`=0. Precharging an idle bank is legal.
- R8: 0/0/1 is auto refresh when `cke` is high at that edge, and self-refresh entry when `cke` is low at that edge (and was high at the edge before).
- R9: A read, write or block write to an idle bank, or an activate to an open bank, sets `cmd_illegal` for that cycle, and bank state stays unchanged.
- R10: Mode load, special mode load, auto refresh and self-refresh entry are illegal while any bank is open, and then leave bank state unchanged.
- R11: `cmd_ap` equals `a8` for read, write and block write and is 0 otherwise. A legal access with `a8`=1 marks its bank idle at that edge.
- R12: All outputs are registered and describe the inputs sampled at the preceding rising edge. `cmd_illegal` is a single-cycle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable strobe |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function strobe, active high |
| ba | input | BANK_W | Bank select |
| a8 | input | 1 | Auto-precharge / precharge-all address bit |
| cmd_oh | output | 14 | Decoded command, one-hot |
| cmd_bank | output | BANK_W | Target bank of the decoded command |
| cmd_ap | output | 1 | Auto-precharge requested with the access |
| cmd_illegal | output | 1 | Command violates the bank state |
| bank_open | output | 2**BANK_W | Per-bank open-row state |

## Verification
The hardest situations to reach from the ports are the state-dependent ones:

- a mode load or refresh arriving while exactly one bank is open;
- self-refresh entry, which needs `cke` to fall on exactly the refresh edge after a high edge.

Directed sequences open each bank on its own, then try those commands and drop `cke` on a refresh edge. A long stretch of biased random strobes follows, with chip select mostly low and `cke` mostly high, so that the banks keep toggling between open and idle. A behavioural model in the bench is compared against every output on every cycle throughout.

// File: rtl/sgcd_pkg.sv
package sgcd_pkg;

   // Command codes; the numeric value is also the one-hot bit position.
   typedef enum logic [3:0] {
      CMD_DESEL  = 4'd0,
      CMD_NOP    = 4'd1,
      CMD_MLOAD  = 4'd2,
      CMD_SMLOAD = 4'd3,
      CMD_ACT    = 4'd4,
      CMD_ACTM   = 4'd5,
      CMD_RD     = 4'd6,
      CMD_WR     = 4'd7,
      CMD_BLKWR  = 4'd8,
      CMD_STOP   = 4'd9,
      CMD_PRE    = 4'd10,
      CMD_PREALL = 4'd11,
      CMD_REF    = 4'd12,
      CMD_SREF   = 4'd13
   } sgcd_cmd_e;

   localparam int unsigned SGCD_NCMD = 14;

   function automatic logic sgcd_is_access(sgcd_cmd_e c);
      return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_BLKWR);
   endfunction

   function automatic logic sgcd_is_activate(sgcd_cmd_e c);
      return (c == CMD_ACT) || (c == CMD_ACTM);
   endfunction

   function automatic logic sgcd_needs_idle(sgcd_cmd_e c);
      return (c == CMD_MLOAD) || (c == CMD_SMLOAD) || (c == CMD_REF) || (c == CMD_SREF);
   endfunction

endpackage

// File: rtl/sgcd_classify.sv
module sgcd_classify
   import sgcd_pkg::*;
(
   input  logic      cke_now,
   input  logic      cke_last,
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   input  logic      dsf,
   input  logic      a8,
   output sgcd_cmd_e cmd
);

   logic [2:0] strobes;
   assign strobes = {ras_n, cas_n, we_n};

   always_comb begin
      cmd = CMD_DESEL;
      if (cke_last && !cs_n) begin
         unique case (strobes)
            3'b111: cmd = CMD_NOP;
            3'b000: cmd = dsf ? CMD_SMLOAD : CMD_MLOAD;
            3'b011: cmd = dsf ? CMD_ACTM : CMD_ACT;
            3'b101: cmd = CMD_RD;
            3'b100: cmd = dsf ? CMD_BLKWR : CMD_WR;
            3'b110: cmd = CMD_STOP;
            3'b010: cmd = a8 ? CMD_PREALL : CMD_PRE;
            3'b001: cmd = cke_now ? CMD_REF : CMD_SREF;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sgcd_bank_track.sv
module sgcd_bank_track
   import sgcd_pkg::*;
#(
   parameter int unsigned BANK_W = 1,
   localparam int unsigned NBANK = 1 << BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sgcd_cmd_e         cmd,
   input  logic [BANK_W-1:0] ba,
   input  logic              a8,
   output logic              illegal,
   output logic [NBANK-1:0]  open_q
);

   logic target_open;
   logic any_open;

   assign target_open = open_q[ba];
   assign any_open    = |open_q;

   always_comb begin
      illegal = 1'b0;
      if (sgcd_is_access(cmd))   illegal = !target_open;
      if (sgcd_is_activate(cmd)) illegal = target_open;
      if (sgcd_needs_idle(cmd))  illegal = any_open;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = (ba == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q[b] <= 1'b0;
         end else if (!illegal) begin
            if (sgcd_is_activate(cmd) && hit)           open_q[b] <= 1'b1;
            else if (sgcd_is_access(cmd) && hit && a8)  open_q[b] <= 1'b0;
            else if (cmd == CMD_PRE && hit)             open_q[b] <= 1'b0;
            else if (cmd == CMD_PREALL)                 open_q[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
   import sgcd_pkg::*;
#(
   parameter int unsigned BANK_W = 1,
   localparam int unsigned NBANK = 1 << BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 dsf,
   input  logic [BANK_W-1:0]    ba,
   input  logic                 a8,
   output logic [SGCD_NCMD-1:0] cmd_oh,
   output logic [BANK_W-1:0]    cmd_bank,
   output logic                 cmd_ap,
   output logic                 cmd_illegal,
   output logic [NBANK-1:0]     bank_open
);

   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_param
      $error("sgram_cmd_decode: BANK_W must be 1..4");
   end

   logic                 cke_last_q;
   sgcd_cmd_e            cmd;
   logic                 illegal;
   logic [SGCD_NCMD-1:0] oh_d;
   logic                 bank_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) cke_last_q <= 1'b1;
      else        cke_last_q <= cke;
   end

   sgcd_classify u_classify (
      .cke_now  (cke),
      .cke_last (cke_last_q),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .dsf      (dsf),
      .a8       (a8),
      .cmd      (cmd)
   );

   sgcd_bank_track #(.BANK_W(BANK_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .ba      (ba),
      .a8      (a8),
      .illegal (illegal),
      .open_q  (bank_open)
   );

   for (genvar i = 0; i < SGCD_NCMD; i++) begin : g_onehot
      assign oh_d[i] = (cmd == sgcd_cmd_e'(i));
   end

   assign bank_cmd = sgcd_is_access(cmd) || sgcd_is_activate(cmd) || (cmd == CMD_PRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_oh      <= SGCD_NCMD'(1) << CMD_NOP;
         cmd_bank    <= '0;
         cmd_ap      <= 1'b0;
         cmd_illegal <= 1'b0;
      end else begin
         cmd_oh      <= oh_d;
         cmd_bank    <= bank_cmd ? ba : '0;
         cmd_ap      <= sgcd_is_access(cmd) && a8;
         cmd_illegal <= illegal;
      end
   end

endmodule

// File: rtl/sgcd_checker.sv
module sgcd_checker
   import sgcd_pkg::*;
#(
   parameter int unsigned BANK_W = 1,
   localparam int unsigned NBANK = 1 << BANK_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic [SGCD_NCMD-1:0] cmd_oh,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_ap,
   input logic                 cmd_illegal,
   input logic [NBANK-1:0]     bank_open
);

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmd_oh) == 1);

   assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(cs_n) |-> cmd_oh[CMD_DESEL] && !cmd_illegal && bank_open == $past(bank_open));

   assert_act_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oh[CMD_ACT] || cmd_oh[CMD_ACTM]) && !cmd_illegal |-> bank_open[cmd_bank]);

   assert_preall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oh[CMD_PREALL] |-> bank_open == '0 && cmd_bank == '0);

   assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && cmd_illegal |-> bank_open == $past(bank_open));

   assert_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oh[CMD_MLOAD] || cmd_oh[CMD_SMLOAD] || cmd_oh[CMD_REF] || cmd_oh[CMD_SREF]) && !cmd_illegal
      |-> bank_open == '0);

   assert_ap_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ap && !cmd_illegal |-> !bank_open[cmd_bank]);

   assert_ap_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ap |-> (cmd_oh[CMD_RD] || cmd_oh[CMD_WR] || cmd_oh[CMD_BLKWR]));

   assert_illegal_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_illegal |-> !(cmd_oh[CMD_DESEL] || cmd_oh[CMD_NOP] || cmd_oh[CMD_STOP]
                        || cmd_oh[CMD_PRE] || cmd_oh[CMD_PREALL]));

endmodule

bind sgram_cmd_decode sgcd_checker #(.BANK_W(BANK_W)) i_sgcd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .cmd_oh      (cmd_oh),
   .cmd_bank    (cmd_bank),
   .cmd_ap      (cmd_ap),
   .cmd_illegal (cmd_illegal),
   .bank_open   (bank_open)
);

// File: tb/test_sgram_cmd_decode.sv
`timescale 1ns/1ps
module test_sgram_cmd_decode;

   localparam int C_DES = 0, C_NOP = 1, C_ML = 2, C_SML = 3, C_ACT = 4, C_ACTM = 5,
                  C_RD = 6, C_WR = 7, C_BW = 8, C_BST = 9, C_PRE = 10, C_PREA = 11,
                  C_REF = 12, C_SREF = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
   logic [0:0] ba = '0;
   logic a8 = 1'b0;
   logic [13:0] cmd_oh;
   logic [0:0]  cmd_bank;
   logic        cmd_ap, cmd_illegal;
   logic [1:0]  bank_open;

   int checks = 0, bad = 0;
   bit started = 0;
   bit done = 0;

   // reference model state
   int  e_cmd = C_NOP;
   int  e_bank = 0;
   bit  e_ap = 0, e_ill = 0;
   bit  m_open [2] = '{0, 0};
   bit  m_ckep = 1;

   always #4 clk = ~clk;

   sgram_cmd_decode i_sgram_cmd_decode (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .dsf(dsf), .ba(ba), .a8(a8), .cmd_oh(cmd_oh), .cmd_bank(cmd_bank),
      .cmd_ap(cmd_ap), .cmd_illegal(cmd_illegal), .bank_open(bank_open)
   );

   function automatic string tag_of(int c);
      case (c)
         C_DES:                return "R2 R3";
         C_NOP, C_RD, C_BST:   return "R5";
         C_ML, C_SML, C_WR, C_BW: return "R4";
         C_ACT, C_ACTM:        return "R6";
         C_PRE, C_PREA:        return "R7";
         default:              return "R8";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_cmd = C_NOP; e_bank = 0; e_ap = 0; e_ill = 0;
         m_open[0] = 0; m_open[1] = 0; m_ckep = 1;
      end else begin
         int c;
         int b;
         bit anyo;
         b = int'(ba);
         anyo = m_open[0] | m_open[1];
         if (!m_ckep || cs_n) c = C_DES;
         else if ( ras_n &&  cas_n &&  we_n) c = C_NOP;
         else if (!ras_n && !cas_n && !we_n) c = dsf ? C_SML : C_ML;
         else if (!ras_n &&  cas_n &&  we_n) c = dsf ? C_ACTM : C_ACT;
         else if ( ras_n && !cas_n &&  we_n) c = C_RD;
         else if ( ras_n && !cas_n && !we_n) c = dsf ? C_BW : C_WR;
         else if ( ras_n &&  cas_n && !we_n) c = C_BST;
         else if (!ras_n &&  cas_n && !we_n) c = a8 ? C_PREA : C_PRE;
         else c = cke ? C_REF : C_SREF;
         e_cmd = c;
         e_ill = 0;
         e_ap  = 0;
         e_bank = 0;
         if (c == C_RD || c == C_WR || c == C_BW) begin
            e_bank = b; e_ap = a8; e_ill = !m_open[b];
            if (!e_ill && a8) m_open[b] = 0;
         end else if (c == C_ACT || c == C_ACTM) begin
            e_bank = b; e_ill = m_open[b];
            if (!e_ill) m_open[b] = 1;
         end else if (c == C_PRE) begin
            e_bank = b; m_open[b] = 0;
         end else if (c == C_PREA) begin
            m_open[0] = 0; m_open[1] = 0;
         end else if (c == C_ML || c == C_SML || c == C_REF || c == C_SREF) begin
            e_ill = anyo;
         end
         m_ckep = cke;
      end
      started = 1;
   end

   task automatic fail_line(string req, string what, int act, int exp);
      bad++;
      $display("FAIL %s R12 %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         int eoh;
         eoh = 1 << e_cmd;
         checks++;
         if (!rst_n && cmd_oh !== 14'(eoh)) fail_line("R1", "reset cmd_oh", int'(cmd_oh), eoh);
         else if (cmd_oh !== 14'(eoh)) fail_line(tag_of(e_cmd), "cmd_oh", int'(cmd_oh), eoh);
         if (cmd_illegal !== e_ill)
            fail_line((e_cmd == C_ML || e_cmd == C_SML || e_cmd == C_REF || e_cmd == C_SREF) ? "R10" : "R9",
                      "cmd_illegal", int'(cmd_illegal), int'(e_ill));
         if (cmd_ap !== e_ap) fail_line("R11", "cmd_ap", int'(cmd_ap), int'(e_ap));
         if (cmd_bank !== 1'(e_bank)) fail_line(tag_of(e_cmd), "cmd_bank", int'(cmd_bank), e_bank);
         if (bank_open !== {m_open[1], m_open[0]})
            fail_line(e_ill ? "R9" : (e_ap ? "R11" : tag_of(e_cmd)), "bank_open",
                      int'(bank_open), int'({m_open[1], m_open[0]}));
      end
   end

   // drive one command at the falling edge: {ras,cas,we} as active-low bits
   task automatic issue(bit k, bit cs, bit [2:0] rcw, bit d, bit b, bit a);
      @(negedge clk);
      cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; dsf = d; ba = b; a8 = a;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      // R1 reset state is checked over these cycles
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      issue(1, 0, 3'b011, 0, 0, 0);  // R6 ACT bank0
      issue(1, 0, 3'b101, 0, 0, 0);  // R5 read bank0
      issue(1, 0, 3'b011, 0, 0, 0);  // R9 ACT open bank
      issue(1, 0, 3'b100, 0, 1, 0);  // R9 write idle bank1
      issue(1, 0, 3'b000, 0, 0, 0);  // R10 mode load with bank open
      issue(1, 0, 3'b001, 0, 0, 0);  // R10 refresh with bank open
      issue(1, 0, 3'b011, 1, 1, 0);  // R4 ACT with mask bank1
      issue(1, 0, 3'b100, 1, 1, 1);  // R4 R11 block write ap closes bank1
      issue(1, 0, 3'b100, 0, 0, 0);  // R4 write bank0
      issue(1, 0, 3'b010, 0, 1, 0);  // R7 precharge idle bank1 only
      issue(1, 1, 3'b000, 0, 0, 0);  // R2 deselect
      issue(1, 0, 3'b110, 1, 0, 0);  // R5 burst stop
      issue(1, 0, 3'b010, 0, 0, 1);  // R7 precharge all
      issue(1, 0, 3'b000, 0, 0, 0);  // R4 mode load legal
      issue(1, 0, 3'b000, 1, 0, 0);  // R4 special mode load
      issue(1, 0, 3'b001, 0, 0, 0);  // R8 refresh
      issue(0, 0, 3'b001, 0, 0, 0);  // R8 self-refresh entry
      issue(0, 0, 3'b011, 0, 0, 0);  // R3 ignored
      issue(1, 0, 3'b011, 0, 0, 0);  // R3 still ignored (cke low before)
      issue(1, 0, 3'b011, 0, 1, 0);  // R6 ACT bank1
      issue(1, 0, 3'b111, 0, 0, 0);  // R5 NOP
      issue(1, 0, 3'b101, 0, 1, 1);  // R11 read ap bank1
      for (int i = 0; i < 4000; i++) begin
         issue(($urandom % 10) != 0, ($urandom % 8) == 0, 3'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom));
         if (i % 997 == 500) begin
            @(negedge clk); rst_n = 1'b0;
            @(negedge clk); rst_n = 1'b1;
         end
      end
      issue(1, 0, 3'b111, 0, 0, 0);
      @(negedge clk);
      @(posedge clk);
      #1;
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule